// File: doc/BRIEF.md
# Resynchronising Serial Transmitter

This block sends 8-bit characters on one asynchronous serial line. Each character is framed with a start bit, eight data bits and one or two stop bits. The block can also leave the line idle in a controlled way. A receiver that attached in the middle of a continuous stream can latch onto a data bit as if it were a start bit. It then stays misaligned for as long as characters follow each other without a pause. The block prevents this by putting idle stretches longer than a frame on the line. These can come after every character, after every N-th character, around a forced break, or between the characters of a sync preamble.

Characters enter through a valid/ready handshake. A divisor sets the bit period on a 16x oversampling tick. The divisor and the framing options are captured when an operation starts, so changing them while the line is busy has no effect on the operation in progress. A break request drives the line low for longer than a frame. A preamble request sends a chosen sync character a chosen number of times, each copy followed by a wide gap. After that, normal back-to-back traffic resumes.

Top module: `uart_resync_tx`

## Requirements
- R1: After reset, tx_o is high and ready_o is high.
- R2: A character is sent as one low start bit, then data bits 0 to 7 (least significant first), then a high stop bit. Every bit lasts 16*(div_i+1) clock cycles, and a plain frame keeps ready_o low for 10 bit times.
- R3: With two_stop_i high, the stop level lasts two bit times, so the frame keeps ready_o low for 11 bit times.
- R4: With guard_en_i high, the line stays high for 20 extra bit times after each character's stop bit(s), and ready_o stays low throughout.
- R5: With gap_every_i = N (N not 0), every N-th data character is followed by 11 high bit times. N = 0 turns this off. When the guard gap also applies, the longer of the two gaps is used.
- R6: A break_i pulse while idle holds tx_o low for 12 bit times, then high for 2 bit times, before ready_o returns high.
- R7: A pre_start_i pulse while idle sends pre_char_i pre_count_i times. Each copy is followed by 12 high bit times, with one idle clock between copies. ready_o stays low until the last gap ends. A pre_count_i of 0 sends nothing.
- R8: ready_o is low during any frame, gap or break. A character is taken only on a cycle where valid_i and ready_o are both high. A request withdrawn before being accepted sends nothing.
- R9: div_i, two_stop_i, guard_en_i and gap_every_i are captured when an operation starts. Changing them mid-operation does not affect it.
- R10: When requests arrive together while idle, break wins over preamble, and preamble wins over data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 8 | Character to send |
| valid_i | input | 1 | data_i is offered |
| ready_o | output | 1 | Block accepts a character this cycle |
| div_i | input | 16 | Oversampling divisor; bit time = 16*(div_i+1) clocks |
| two_stop_i | input | 1 | Two stop bits |
| guard_en_i | input | 1 | 20-bit idle guard after every character |
| gap_every_i | input | 8 | Long gap after every N-th character, 0 = off |
| break_i | input | 1 | Request a break |
| pre_start_i | input | 1 | Start a preamble |
| pre_char_i | input | 8 | Preamble sync character |
| pre_count_i | input | 4 | Number of preamble characters |
| tx_o | output | 1 | Serial line, idle high |

## Verification
On every cycle, the assertions check that a character accepted on the handshake is followed at once by a low start level. They check that the line and the shift register change only on a bit strobe. They also check that the captured configuration holds while an operation runs, and that the oversampling counters stay within the captured divisor. The bench's scenarios cover the rest by sampling the line at mid-bit and counting busy cycles: bit order, stop-bit count, guard and periodic gap lengths, the break shape, preamble spacing, request priority, and the lack of effect of mid-operation reconfiguration.

// File: rtl/uart_rtx_pkg.sv
package uart_rtx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_GAP,
    ST_BRK
  } tx_state_e;
endpackage

// File: rtl/uart_rtx_tick.sv
module uart_rtx_tick #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bit_o
);
  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic [DIV_W-1:0] clk_cnt_q;
  logic [SUB_W-1:0] sub_cnt_q;
  logic             tick;

  assign tick  = en_i && (clk_cnt_q == div_i);
  assign bit_o = tick && (sub_cnt_q == SUB_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_cnt_q <= '0;
      sub_cnt_q <= '0;
    end else if (!en_i) begin
      clk_cnt_q <= '0;
      sub_cnt_q <= '0;
    end else if (tick) begin
      clk_cnt_q <= '0;
      sub_cnt_q <= (sub_cnt_q == SUB_LAST) ? '0 : sub_cnt_q + 1'b1;
    end else begin
      clk_cnt_q <= clk_cnt_q + 1'b1;
    end
  end

  AST_CLK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (clk_cnt_q <= div_i)); // R9
  AST_SUB_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (clk_cnt_q != div_i)) |=> $stable(sub_cnt_q)); // R2
endmodule

// File: rtl/uart_rtx_gap.sv
module uart_rtx_gap #(
  parameter int CNT_W      = 8,
  parameter int GAP_W      = 6,
  parameter int GUARD_BITS = 20,
  parameter int LONG_BITS  = 11,
  parameter int PRE_BITS   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             char_done_i,
  input  logic             is_pre_i,
  input  logic             guard_en_i,
  input  logic [CNT_W-1:0] every_i,
  output logic [GAP_W-1:0] gap_bits_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             long_hit;

  assign long_hit = !is_pre_i && (every_i != '0) &&
                    (({1'b0, cnt_q} + 1'b1) >= {1'b0, every_i});

  always_comb begin
    gap_bits_o = '0;
    if (is_pre_i) gap_bits_o = GAP_W'(PRE_BITS);
    if (guard_en_i && (gap_bits_o < GAP_W'(GUARD_BITS))) gap_bits_o = GAP_W'(GUARD_BITS);
    if (long_hit && (gap_bits_o < GAP_W'(LONG_BITS))) gap_bits_o = GAP_W'(LONG_BITS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (char_done_i && !is_pre_i) begin
      if (every_i == '0 || long_hit) cnt_q <= '0;
      else                           cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_rtx_seq.sv
module uart_rtx_seq
  import uart_rtx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 16,
  parameter int CNT_W      = 8,
  parameter int PRE_W      = 4,
  parameter int GAP_W      = 6,
  parameter int BRK_BITS   = 12,
  parameter int BRK_MARK   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              two_stop_i,
  input  logic              guard_en_i,
  input  logic [CNT_W-1:0]  gap_every_i,
  input  logic              break_i,
  input  logic              pre_start_i,
  input  logic [DATA_W-1:0] pre_char_i,
  input  logic [PRE_W-1:0]  pre_count_i,
  input  logic              bit_stb_i,
  input  logic [GAP_W-1:0]  gap_bits_i,
  output logic              tick_en_o,
  output logic [DIV_W-1:0]  div_q_o,
  output logic              char_done_o,
  output logic              is_pre_o,
  output logic              guard_q_o,
  output logic [CNT_W-1:0]  every_q_o,
  output logic              tx_o
);
  tx_state_e         st_q;
  logic [DATA_W-1:0] sh_q;
  logic [GAP_W-1:0]  cnt_q;
  logic [PRE_W-1:0]  pre_left_q;
  logic              two_q;
  logic              tx_q;
  logic              pre_now;

  assign pre_now     = pre_start_i && (pre_count_i != '0);
  assign ready_o     = (st_q == ST_IDLE) && !break_i && !pre_now && (pre_left_q == '0);
  assign tick_en_o   = (st_q != ST_IDLE);
  assign char_done_o = (st_q == ST_STOP) && bit_stb_i && (cnt_q == '0);
  assign tx_o        = tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      sh_q       <= '0;
      cnt_q      <= '0;
      pre_left_q <= '0;
      two_q      <= 1'b0;
      guard_q_o  <= 1'b0;
      every_q_o  <= '0;
      div_q_o    <= '0;
      is_pre_o   <= 1'b0;
      tx_q       <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          tx_q <= 1'b1;
          if (break_i || pre_now || pre_left_q != '0 || valid_i) begin
            div_q_o   <= div_i;
            two_q     <= two_stop_i;
            guard_q_o <= guard_en_i;
            every_q_o <= gap_every_i;
          end
          if (break_i) begin
            st_q  <= ST_BRK;
            cnt_q <= GAP_W'(BRK_BITS - 1);
            tx_q  <= 1'b0;
          end else if (pre_now) begin
            st_q       <= ST_START;
            sh_q       <= pre_char_i;
            pre_left_q <= pre_count_i - 1'b1;
            is_pre_o   <= 1'b1;
            tx_q       <= 1'b0;
          end else if (pre_left_q != '0) begin
            st_q       <= ST_START;
            sh_q       <= pre_char_i;
            pre_left_q <= pre_left_q - 1'b1;
            is_pre_o   <= 1'b1;
            tx_q       <= 1'b0;
          end else if (valid_i) begin
            st_q     <= ST_START;
            sh_q     <= data_i;
            is_pre_o <= 1'b0;
            tx_q     <= 1'b0;
          end
        end
        ST_START: begin
          if (bit_stb_i) begin
            st_q  <= ST_DATA;
            tx_q  <= sh_q[0];
            sh_q  <= sh_q >> 1;
            cnt_q <= '0;
          end
        end
        ST_DATA: begin
          if (bit_stb_i) begin
            if (cnt_q == GAP_W'(DATA_W - 1)) begin
              st_q  <= ST_STOP;
              tx_q  <= 1'b1;
              cnt_q <= two_q ? GAP_W'(1) : '0;
            end else begin
              tx_q  <= sh_q[0];
              sh_q  <= sh_q >> 1;
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (bit_stb_i) begin
            if (cnt_q == '0) begin
              if (gap_bits_i == '0) begin
                st_q <= ST_IDLE;
              end else begin
                st_q  <= ST_GAP;
                cnt_q <= gap_bits_i - 1'b1;
              end
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
        end
        ST_GAP: begin
          tx_q <= 1'b1;
          if (bit_stb_i) begin
            if (cnt_q == '0) st_q <= ST_IDLE;
            else             cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_BRK: begin
          if (bit_stb_i) begin
            if (cnt_q == '0) begin
              st_q  <= ST_GAP;
              tx_q  <= 1'b1;
              cnt_q <= GAP_W'(BRK_MARK - 1);
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !tx_o); // R2
  AST_LINE_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && st_q != ST_GAP && !bit_stb_i) |=> $stable(tx_o)); // R2
  AST_SHIFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && !bit_stb_i) |=> $stable(sh_q)); // R8
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> ($stable(div_q_o) && $stable(two_q) && $stable(guard_q_o))); // R9
  AST_BRK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BRK) |-> !tx_o); // R6
endmodule

// File: rtl/uart_resync_tx.sv
module uart_resync_tx #(
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 16,
  parameter int CNT_W      = 8,
  parameter int PRE_W      = 4,
  parameter int OVS        = 16,
  parameter int GUARD_BITS = 20,
  parameter int LONG_BITS  = 11,
  parameter int PRE_BITS   = 12,
  parameter int BRK_BITS   = 12,
  parameter int BRK_MARK   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              two_stop_i,
  input  logic              guard_en_i,
  input  logic [CNT_W-1:0]  gap_every_i,
  input  logic              break_i,
  input  logic              pre_start_i,
  input  logic [DATA_W-1:0] pre_char_i,
  input  logic [PRE_W-1:0]  pre_count_i,
  output logic              tx_o
);
  localparam int GAP_W = $clog2(GUARD_BITS + LONG_BITS + PRE_BITS + BRK_BITS + BRK_MARK + DATA_W);

  logic             bit_stb;
  logic             tick_en;
  logic [DIV_W-1:0] div_q;
  logic             char_done;
  logic             is_pre;
  logic             guard_q;
  logic [CNT_W-1:0] every_q;
  logic [GAP_W-1:0] gap_bits;

  uart_rtx_tick #(.DIV_W(DIV_W), .OVS(OVS)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tick_en),
    .div_i (div_q),
    .bit_o (bit_stb)
  );

  uart_rtx_gap #(
    .CNT_W(CNT_W), .GAP_W(GAP_W), .GUARD_BITS(GUARD_BITS),
    .LONG_BITS(LONG_BITS), .PRE_BITS(PRE_BITS)
  ) u_gap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .char_done_i(char_done),
    .is_pre_i   (is_pre),
    .guard_en_i (guard_q),
    .every_i    (every_q),
    .gap_bits_o (gap_bits)
  );

  uart_rtx_seq #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .CNT_W(CNT_W), .PRE_W(PRE_W),
    .GAP_W(GAP_W), .BRK_BITS(BRK_BITS), .BRK_MARK(BRK_MARK)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (data_i),
    .valid_i    (valid_i),
    .ready_o    (ready_o),
    .div_i      (div_i),
    .two_stop_i (two_stop_i),
    .guard_en_i (guard_en_i),
    .gap_every_i(gap_every_i),
    .break_i    (break_i),
    .pre_start_i(pre_start_i),
    .pre_char_i (pre_char_i),
    .pre_count_i(pre_count_i),
    .bit_stb_i  (bit_stb),
    .gap_bits_i (gap_bits),
    .tick_en_o  (tick_en),
    .div_q_o    (div_q),
    .char_done_o(char_done),
    .is_pre_o   (is_pre),
    .guard_q_o  (guard_q),
    .every_q_o  (every_q),
    .tx_o       (tx_o)
  );
endmodule

// File: tb/uart_resync_tx_bench.sv
module uart_resync_tx_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  data_i = '0;
  logic        valid_i = 1'b0;
  logic        ready_o;
  logic [15:0] div_i = '0;
  logic        two_stop_i = 1'b0;
  logic        guard_en_i = 1'b0;
  logic [7:0]  gap_every_i = '0;
  logic        break_i = 1'b0;
  logic        pre_start_i = 1'b0;
  logic [7:0]  pre_char_i = '0;
  logic [3:0]  pre_count_i = '0;
  logic        tx_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  uart_resync_tx u_uart_resync_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .valid_i(valid_i),
    .ready_o(ready_o), .div_i(div_i), .two_stop_i(two_stop_i),
    .guard_en_i(guard_en_i), .gap_every_i(gap_every_i), .break_i(break_i),
    .pre_start_i(pre_start_i), .pre_char_i(pre_char_i),
    .pre_count_i(pre_count_i), .tx_o(tx_o)
  );

  always #5 clk_i = ~clk_i;

  // {data, two_stop, guard}
  localparam logic [9:0] VEC [5] = '{
    {8'h41, 1'b0, 1'b0},
    {8'hA5, 1'b0, 1'b0},
    {8'h00, 1'b1, 1'b0},
    {8'hFF, 1'b0, 1'b1},
    {8'h80, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [7:0] ch, input int b);
    if (b == 0) return 1'b0;
    if (b <= 8) return ch[b-1];
    return 1'b1;
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // Waits for the accepting edge, then watches the line at mid-bit until ready returns.
  task automatic watch_op(input string req, input int len, input logic [7:0] ch,
                          input int per, input bit brk, input int exp_t, input bit chg);
    int t;
    int bad;
    logic e;
    t = -1;
    bad = 0;
    @(posedge clk_i);
    for (int kk = 1; kk <= 20000; kk++) begin
      @(negedge clk_i);
      if (kk == 1) begin
        valid_i = 1'b0;
        break_i = 1'b0;
        pre_start_i = 1'b0;
      end
      if (chg && kk == 40) begin
        two_stop_i = 1'b1;
        div_i = 16'd3;
      end
      #1;
      if (ready_o) begin
        t = kk - 1;
        break;
      end
      if ((kk - 1) % len == len / 2) begin
        int j;
        j = (kk - 1) / len;
        e = brk ? (j >= 12) : exp_bit(ch, j % per);
        if (tx_o !== e) bad++;
      end
    end
    chk(t == exp_t, req, "busy cycles", t, exp_t);
    chk(bad == 0, req, "mid-bit line mismatches", bad, 0);
  endtask

  task automatic send(input logic [7:0] ch);
    @(negedge clk_i);
    data_i = ch;
    valid_i = 1'b1;
  endtask

  initial begin
    do_reset();
    #1;
    chk(tx_o === 1'b1, "R1", "idle line after reset", int'(tx_o), 1);
    chk(ready_o === 1'b1, "R1", "ready after reset", int'(ready_o), 1);

    // R2 R3 R4: table walk, divisor 0 => 16 clocks per bit
    for (int v = 0; v < 5; v++) begin
      int per;
      two_stop_i = VEC[v][1];
      guard_en_i = VEC[v][0];
      per = 10 + int'(VEC[v][1]) + (VEC[v][0] ? 20 : 0);
      send(VEC[v][9:2]);
      watch_op(VEC[v][0] ? "R4" : (VEC[v][1] ? "R3" : "R2"), 16, VEC[v][9:2],
               per, 1'b0, 16 * per, 1'b0);
    end
    two_stop_i = 1'b0;
    guard_en_i = 1'b0;

    // R2: divisor 1 => 32 clocks per bit
    div_i = 16'd1;
    send(8'h3C);
    watch_op("R2", 32, 8'h3C, 10, 1'b0, 320, 1'b0);
    div_i = 16'd0;

    // R5: long gap after every 3rd character
    do_reset();
    gap_every_i = 8'd3;
    send(8'h11); watch_op("R5", 16, 8'h11, 10, 1'b0, 160, 1'b0);
    send(8'h22); watch_op("R5", 16, 8'h22, 10, 1'b0, 160, 1'b0);
    send(8'h33); watch_op("R5", 16, 8'h33, 21, 1'b0, 336, 1'b0);
    send(8'h44); watch_op("R5", 16, 8'h44, 10, 1'b0, 160, 1'b0);
    gap_every_i = 8'd0;

    // R6: break shape
    @(negedge clk_i);
    break_i = 1'b1;
    watch_op("R6", 16, 8'h00, 1, 1'b1, 224, 1'b0);

    // R7: two spaced preamble characters, then back-to-back data
    @(negedge clk_i);
    pre_char_i = 8'h55;
    pre_count_i = 4'd2;
    pre_start_i = 1'b1;
    watch_op("R7", 16, 8'h55, 22, 1'b0, 705, 1'b0);
    send(8'h0F); watch_op("R7", 16, 8'h0F, 10, 1'b0, 160, 1'b0);

    // R10: break beats preamble and data
    @(negedge clk_i);
    data_i = 8'h0F; valid_i = 1'b1; pre_count_i = 4'd1; pre_start_i = 1'b1; break_i = 1'b1;
    watch_op("R10", 16, 8'h00, 1, 1'b1, 224, 1'b0);
    // R10: preamble beats data
    @(negedge clk_i);
    data_i = 8'h0F; valid_i = 1'b1; pre_char_i = 8'hC3; pre_count_i = 4'd1; pre_start_i = 1'b1;
    watch_op("R10", 16, 8'hC3, 22, 1'b0, 352, 1'b0);

    // R8: withdrawn data offer is never sent
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk_i);
        #1;
        if (tx_o !== 1'b1 || ready_o !== 1'b1) bad++;
      end
      chk(bad == 0, "R8", "cycles not idle after withdrawn offer", bad, 0);
    end

    // R7: preamble with count 0 sends nothing
    @(negedge clk_i);
    pre_count_i = 4'd0; pre_start_i = 1'b1;
    #1;
    chk(ready_o === 1'b1, "R7", "ready with empty preamble", int'(ready_o), 1);
    @(negedge clk_i);
    pre_start_i = 1'b0;
    #1;
    chk(tx_o === 1'b1, "R7", "line after empty preamble", int'(tx_o), 1);

    // R9: mid-frame config change has no effect; next frame uses it
    send(8'h96); watch_op("R9", 16, 8'h96, 10, 1'b0, 160, 1'b1);
    send(8'h69); watch_op("R9", 64, 8'h69, 11, 1'b0, 704, 1'b0);
    div_i = 16'd0;
    two_stop_i = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule